// File: doc/BRIEF.md
# Capacitive sense counter unit

This block is the digital timing and counting core behind a capacitive touch sensor. A relaxation oscillator whose frequency depends on the sense capacitance, and an analog comparator that watches an integration capacitor, arrive as asynchronous inputs. A reference clock arrives as a one-cycle enable pulse in the system clock domain. One pair of counters, an 8-bit event counter and a 16-bit reference counter, serves three measurement modes. The frequency-difference mode counts oscillator edges over a window of reference ticks. The period mode counts reference ticks over a programmed number of oscillator cycles. The charge mode counts reference ticks until the comparator trips.

Software sets the mode and the interval settings and pulses `start`. The block clears its counters, measures, and raises `done` for one cycle once the count is final. The count and the overflow flag then stay fixed until the next `start`. A `start` issued during a measurement abandons it and begins a fresh one.

Top module: `cap_sense_counter`

## Requirements
- R1: After reset `result` is 0, `overflow` is 0, `done` is 0 and no measurement is running.
- R2: With `mode` 2'b00 or 2'b11 (frequency difference), each synchronized rising edge of `osc_in` adds one to an 8-bit count. Each `ref_tick` adds one to a window count. The measurement ends on the tick that brings the window count to 256 << `win_sel`: 256, 512, 1024 or 2048 for `win_sel` 0 to 3. `result` shows the 8-bit count zero-extended to 16 bits, and an edge in that final cycle is included.
- R3: In frequency-difference mode, an oscillator edge arriving while the 8-bit count is 255 wraps the count to 0 and sets `overflow`. The flag stays set until the next start.
- R4: With `mode` 2'b01 (period), each `ref_tick` adds one to a 16-bit count shown on `result`. The measurement ends on the synchronized oscillator rising edge that brings the oscillator cycle count to `cyc_target` (1 to 63), and a tick in that final cycle is included.
- R5: In period mode a `cyc_target` of 0 sets the window to 64 oscillator cycles.
- R6: The 16-bit reference count stops at 65535. A further `ref_tick` leaves it at 65535 and sets `overflow`.
- R7: With `mode` 2'b10 (charge), each `ref_tick` adds one to the 16-bit count shown on `result`. The measurement ends in the first cycle in which the synchronized `cmp_in` is high, and a tick in that cycle is included.
- R8: In charge mode a nonzero `timeout` T ends the measurement on the tick that brings the count to T and sets `overflow`, unless the comparator trips in that same cycle. A `timeout` of 0 disables this ending.
- R9: `done` is high for exactly one cycle per completed measurement, the same cycle in which `result` first shows the final count. After that, `result` and `overflow` hold until the next `start`.
- R10: A `start` sampled high clears both counts and `overflow`, latches `mode`, `win_sel`, `cyc_target` and `timeout`, and begins a measurement. Ticks and edges in that cycle are not counted. A `start` during a running measurement restarts it, and the abandoned run gives no `done`.
- R11: `osc_in` and `cmp_in` pass through two synchronizer flops. A level first sampled high at clock edge k takes effect at edge k+2, so a count or `done` that it causes is visible after edge k+2. A `ref_tick` sampled at edge k takes effect at edge k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Clear and begin (or restart) a measurement |
| mode | input | 2 | 00/11 frequency difference, 01 period, 10 charge |
| win_sel | input | 2 | Frequency-difference window, 256 << win_sel ticks |
| cyc_target | input | 6 | Period-mode oscillator cycle count, 0 means 64 |
| timeout | input | 16 | Charge-mode tick limit, 0 disables |
| ref_tick | input | 1 | Reference clock enable pulse, system domain |
| osc_in | input | 1 | Relaxation oscillator, asynchronous |
| cmp_in | input | 1 | Integration comparator, asynchronous |
| result | output | 16 | Measurement count |
| overflow | output | 1 | Wrap, saturation or timeout flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
Several latencies apply. A `ref_tick` counts at the edge that samples it. An oscillator edge or a comparator level counts two edges after it is first sampled. `done`, the final `result` and the final `overflow` all appear together right after the ending edge. The bench drives inputs on falling edges. It steps a behavioural model on each rising edge from the same sampled inputs, with the synchronizer delay modelled as a plain two-deep delay line. It then compares all three outputs on the following falling edge, so every one of these latencies is checked in every cycle. Directed checks add the value ranges expected from the stimulus, the exact edge on which `done` follows a single oscillator rise, and the count of `done` pulses around a restart.

// File: rtl/cs_meas_pkg.sv
// Shared types of the capacitive sense counter unit.
package cs_meas_pkg;
    // Measurement mode; code 2'b11 behaves as frequency difference.
    typedef enum logic [1:0] {
        MODE_FREQ     = 2'b00,
        MODE_PERIOD   = 2'b01,
        MODE_CHARGE   = 2'b10,
        MODE_FREQ_ALT = 2'b11
    } cs_mode_e;

    // Measurement sequencer state.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } cs_state_e;
endpackage

// File: rtl/cs_sync_edge.sv
// Synchronizer for one asynchronous input.
// Passes din through STAGES flops on clk. With EDGE_OUT=1, q is a
// one-cycle pulse on each synchronized rising edge; with EDGE_OUT=0,
// q is the synchronized level. Assumes STAGES >= 2.
module cs_sync_edge #(
    parameter int STAGES   = 2,
    parameter bit EDGE_OUT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
    end

    generate
        if (EDGE_OUT) begin : g_edge
            logic last;
            // Remember the previous synchronized level for edge detection.
            always_ff @(posedge clk) begin
                if (!rst_n) last <= 1'b0;
                else        last <= chain[STAGES-1];
            end
            assign q = chain[STAGES-1] & ~last;
        end else begin : g_level
            assign q = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/cs_event_counter.sv
// Cleared event counter with a sticky flag.
// SATURATE=1: holds at its maximum and sets flag on a further event.
// SATURATE=0: wraps to zero and sets flag when it passes its maximum.
// clr has priority over inc.
module cs_event_counter #(
    parameter int W        = 8,
    parameter bit SATURATE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         flag
);
    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] ONE  = W'(1);

    generate
        if (SATURATE) begin : g_sat
            // Count events, holding at the maximum.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    cnt  <= '0;
                    flag <= 1'b0;
                end else if (inc) begin
                    if (cnt == MAXV) flag <= 1'b1;
                    else             cnt  <= cnt + ONE;
                end
            end

            p_sat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (cnt == MAXV && !clr) |=> (cnt == MAXV));
            p_sat_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (cnt == MAXV && inc && !clr) |=> flag);
        end else begin : g_wrap
            // Count events, wrapping past the maximum.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    cnt  <= '0;
                    flag <= 1'b0;
                end else if (inc) begin
                    cnt <= cnt + ONE;
                    if (cnt == MAXV) flag <= 1'b1;
                end
            end

            p_wrap_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (flag && !clr) |=> flag);
        end
    endgenerate
endmodule

// File: rtl/cs_meas_ctrl.sv
// Measurement sequencer of the capacitive sense counter unit.
// Latches the configuration on start and steers increments to the two
// counters. It detects the mode-specific end of a measurement and
// issues the done pulse and the timeout flag. Assumes the counters
// clear on cnt_clr, and that osc_rise and cmp_lvl are already
// synchronized to clk.
module cs_meas_ctrl
    import cs_meas_pkg::*;
#(
    parameter int OSC_W         = 8,
    parameter int REF_W         = 16,
    parameter int CYC_W         = 6,
    parameter int WSEL_W        = 2,
    parameter int WIN_BASE_LOG2 = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [WSEL_W-1:0] win_sel,
    input  logic [CYC_W-1:0]  cyc_target,
    input  logic [REF_W-1:0]  timeout,
    input  logic              ref_tick,
    input  logic              osc_rise,
    input  logic              cmp_lvl,
    input  logic [OSC_W-1:0]  osc_cnt,
    input  logic [REF_W-1:0]  ref_cnt,
    output logic              cnt_clr,
    output logic              osc_inc,
    output logic              ref_inc,
    output logic              done,
    output logic              tmo_flag,
    output cs_mode_e          mode_q,
    output logic              running
);
    localparam logic [REF_W-1:0] REF_ONE  = REF_W'(1);
    localparam logic [OSC_W-1:0] OSC_ONE  = OSC_W'(1);
    localparam logic [OSC_W-1:0] CYC_FULL = OSC_W'(2 ** CYC_W);

    cs_state_e        state;
    logic [REF_W-1:0] win_q;
    logic [OSC_W-1:0] tgt_q;
    logic [REF_W-1:0] tmo_q;
    logic [REF_W-1:0] ref_next;
    logic [OSC_W-1:0] osc_next;
    logic             win_hit;
    logic             cyc_hit;
    logic             tmo_hit;
    logic             end_evt;
    logic             fin;

    // Latch the configuration of the measurement being started.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_FREQ;
            win_q  <= '0;
            tgt_q  <= '0;
            tmo_q  <= '0;
        end else if (start) begin
            mode_q <= cs_mode_e'(mode);
            win_q  <= REF_ONE << (WIN_BASE_LOG2 + int'(win_sel));
            tgt_q  <= (cyc_target == '0) ? CYC_FULL
                                         : {{(OSC_W-CYC_W){1'b0}}, cyc_target};
            tmo_q  <= timeout;
        end
    end

    // Detect the end condition of each mode from this cycle's events.
    always_comb begin
        ref_next = ref_cnt + REF_ONE;
        osc_next = osc_cnt + OSC_ONE;
        win_hit  = ref_tick && (ref_next == win_q);
        cyc_hit  = osc_rise && (osc_next == tgt_q);
        tmo_hit  = ref_tick && (tmo_q != '0) && (ref_next == tmo_q);
        case (mode_q)
            MODE_PERIOD: end_evt = cyc_hit;
            MODE_CHARGE: end_evt = cmp_lvl || tmo_hit;
            default:     end_evt = win_hit;
        endcase
        fin = (state == ST_RUN) && end_evt && !start;
    end

    assign running = (state == ST_RUN);
    assign cnt_clr = start;
    assign ref_inc = running && ref_tick && !start;
    assign osc_inc = running && osc_rise && !start && (mode_q != MODE_CHARGE);

    // Sequence between idle and running.
    always_ff @(posedge clk) begin
        if (!rst_n)   state <= ST_IDLE;
        else if (start) state <= ST_RUN;
        else if (fin)   state <= ST_IDLE;
    end

    // Issue the one-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= fin;
    end

    // Record a charge measurement that ended on its timeout.
    always_ff @(posedge clk) begin
        if (!rst_n || start) tmo_flag <= 1'b0;
        else if (fin && mode_q == MODE_CHARGE && !cmp_lvl && tmo_hit) tmo_flag <= 1'b1;
    end

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_restart_no_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done);
    p_done_leaves_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !running);
    p_tmo_only_charge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_flag |-> (mode_q == MODE_CHARGE));
endmodule

// File: rtl/cap_sense_counter.sv
// Capacitive sense counter unit (top).
// Synchronizes the oscillator and comparator inputs and runs the
// sequencer over one 8-bit wrapping event counter and one 16-bit
// saturating reference counter. It presents the count of the selected
// mode, an overflow flag and a done pulse. Assumes ref_tick is a
// one-cycle enable pulse in the clk domain.
module cap_sense_counter
    import cs_meas_pkg::*;
#(
    parameter int OSC_W         = 8,
    parameter int REF_W         = 16,
    parameter int CYC_W         = 6,
    parameter int WSEL_W        = 2,
    parameter int WIN_BASE_LOG2 = 8,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [WSEL_W-1:0] win_sel,
    input  logic [CYC_W-1:0]  cyc_target,
    input  logic [REF_W-1:0]  timeout,
    input  logic              ref_tick,
    input  logic              osc_in,
    input  logic              cmp_in,
    output logic [REF_W-1:0]  result,
    output logic              overflow,
    output logic              done
);
    localparam int N_ASYNC = 2;

    logic [N_ASYNC-1:0] async_in;
    logic [N_ASYNC-1:0] sync_q;
    logic [OSC_W-1:0]   osc_cnt;
    logic [REF_W-1:0]   ref_cnt;
    logic               osc_flag;
    logic               ref_flag;
    logic               tmo_flag;
    logic               cnt_clr;
    logic               osc_inc;
    logic               ref_inc;
    logic               running;
    cs_mode_e           mode_q;

    assign async_in = {cmp_in, osc_in};

    // Index 0 is the oscillator (edge pulse), index 1 the comparator (level).
    for (genvar gi = 0; gi < N_ASYNC; gi++) begin : g_sync
        cs_sync_edge #(
            .STAGES   (SYNC_STAGES),
            .EDGE_OUT (gi == 0)
        ) i_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (async_in[gi]),
            .q     (sync_q[gi])
        );
    end

    cs_meas_ctrl #(
        .OSC_W         (OSC_W),
        .REF_W         (REF_W),
        .CYC_W         (CYC_W),
        .WSEL_W        (WSEL_W),
        .WIN_BASE_LOG2 (WIN_BASE_LOG2)
    ) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mode       (mode),
        .win_sel    (win_sel),
        .cyc_target (cyc_target),
        .timeout    (timeout),
        .ref_tick   (ref_tick),
        .osc_rise   (sync_q[0]),
        .cmp_lvl    (sync_q[1]),
        .osc_cnt    (osc_cnt),
        .ref_cnt    (ref_cnt),
        .cnt_clr    (cnt_clr),
        .osc_inc    (osc_inc),
        .ref_inc    (ref_inc),
        .done       (done),
        .tmo_flag   (tmo_flag),
        .mode_q     (mode_q),
        .running    (running)
    );

    cs_event_counter #(.W(OSC_W), .SATURATE(1'b0)) i_osc_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (osc_inc),
        .cnt   (osc_cnt),
        .flag  (osc_flag)
    );

    cs_event_counter #(.W(REF_W), .SATURATE(1'b1)) i_ref_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (ref_inc),
        .cnt   (ref_cnt),
        .flag  (ref_flag)
    );

    // Present the count that belongs to the latched mode.
    always_comb begin
        if (mode_q == MODE_FREQ || mode_q == MODE_FREQ_ALT)
            result = {{(REF_W-OSC_W){1'b0}}, osc_cnt};
        else
            result = ref_cnt;
    end

    assign overflow = osc_flag | ref_flag | tmo_flag;

    p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!overflow && result == '0));
    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start) |=> ($stable(result) && $stable(overflow)));
    p_done_value_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> $stable(result));
endmodule

// File: tb/test_cap_sense_counter.sv
module test_cap_sense_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [1:0]  win_sel = 2'b00;
    logic [5:0]  cyc_target = 6'd0;
    logic [15:0] timeout = 16'd0;
    logic        ref_tick = 1'b0;
    logic        osc_in = 1'b0;
    logic        cmp_in = 1'b0;
    logic [15:0] result;
    logic        overflow;
    logic        done;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit chk_en = 1'b0;
    int osc_half = 0;
    bit osc_manual = 1'b0;
    int ref_div = 1;

    // behavioural model state
    int  m_oc, m_rc, m_mode, m_ws, m_tg, m_to;
    bit  m_run, m_done, m_owrap, m_rsat, m_tflag;
    bit  m_o1, m_o2, m_o3, m_c1, m_c2;

    always #10 clk = ~clk;   // 50 MHz

    cap_sense_counter i_cap_sense_counter (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .win_sel(win_sel),
        .cyc_target(cyc_target), .timeout(timeout), .ref_tick(ref_tick),
        .osc_in(osc_in), .cmp_in(cmp_in), .result(result), .overflow(overflow),
        .done(done)
    );

    task automatic chk(input string tag, input bit ok, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic string res_tag(input int md);
        return (md == 1) ? "R4 result" : ((md == 2) ? "R7 result" : "R2 result");
    endfunction

    function automatic string ovf_tag(input int md);
        return (md == 1) ? "R6 overflow" : ((md == 2) ? "R8 overflow" : "R3 overflow");
    endfunction

    // Behavioural reference, stepped on each rising edge with sampled inputs.
    always @(posedge clk) begin
        bit rise, fin, th;
        int win;
        rise = m_o2 & ~m_o3;
        if (!rst_n) begin
            m_oc = 0; m_rc = 0; m_mode = 0; m_ws = 0; m_tg = 0; m_to = 0;
            m_run = 0; m_done = 0; m_owrap = 0; m_rsat = 0; m_tflag = 0;
            m_o1 = 0; m_o2 = 0; m_o3 = 0; m_c1 = 0; m_c2 = 0;
        end else begin
            m_done = 0;
            if (start) begin
                m_oc = 0; m_rc = 0; m_owrap = 0; m_rsat = 0; m_tflag = 0;
                m_run = 1; m_mode = mode; m_ws = win_sel; m_tg = cyc_target; m_to = timeout;
            end else if (m_run) begin
                fin = 0;
                win = 256 << m_ws;
                if (m_mode == 1) fin = rise && (m_oc + 1 == ((m_tg == 0) ? 64 : m_tg));
                else if (m_mode == 2) begin
                    th = ref_tick && (m_to != 0) && (m_rc + 1 == m_to);
                    fin = m_c2 || th;
                    if (!m_c2 && th) m_tflag = 1;
                end else fin = ref_tick && (m_rc + 1 == win);
                if (rise && m_mode != 2) begin
                    if (m_oc == 255) begin m_oc = 0; m_owrap = 1; end
                    else m_oc++;
                end
                if (ref_tick) begin
                    if (m_rc == 65535) m_rsat = 1;
                    else m_rc++;
                end
                if (fin) begin m_run = 0; m_done = 1; end
            end
            m_o3 = m_o2; m_o2 = m_o1; m_o1 = osc_in;
            m_c2 = m_c1; m_c1 = cmp_in;
        end
    end

    // Compare outputs with the model every cycle away from the active edge.
    always @(negedge clk) begin
        int er;
        if (chk_en) begin
            er = (m_mode == 1 || m_mode == 2) ? m_rc : m_oc;
            chk(res_tag(m_mode), result == 16'(er), int'(result), er);
            chk(ovf_tag(m_mode), overflow == (m_owrap | m_rsat | m_tflag),
                int'(overflow), int'(m_owrap | m_rsat | m_tflag));
            chk("R9 done", done == m_done, int'(done), int'(m_done));
        end
    end

    // Oscillator and reference tick generators.
    initial begin
        int ph = 0;
        int rc = 0;
        forever begin
            @(negedge clk);
            if (osc_half == 0) osc_in = osc_manual;
            else begin
                ph++;
                if (ph >= osc_half) begin ph = 0; osc_in = ~osc_in; end
            end
            rc = (rc + 1 >= ref_div) ? 0 : rc + 1;
            ref_tick = (rc == 0);
        end
    end

    // Watchdog.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    task automatic meas(input logic [1:0] md, input logic [1:0] ws, input logic [5:0] tg,
                        input logic [15:0] tm, input int maxc, output int ndone);
        @(negedge clk);
        mode = md; win_sel = ws; cyc_target = tg; timeout = tm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ndone = 0;
        for (int i = 0; i < maxc; i++) begin
            if (done) begin ndone++; break; end
            @(negedge clk);
        end
    endtask

    task automatic tail(inout int ndone);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (done) ndone++;
        end
    endtask

    initial begin
        int nd;
        int r0;
        repeat (3) @(negedge clk);
        chk_en = 1'b1;
        chk("R1 result", result == 16'd0, int'(result), 0);
        chk("R1 overflow", overflow == 1'b0, int'(overflow), 0);
        chk("R1 done", done == 1'b0, int'(done), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2: window 256 ticks, tick every cycle, osc period 2 -> about 128
        ref_div = 1; osc_half = 1;
        meas(2'b00, 2'b00, 6'd0, 16'd0, 3000, nd);
        chk("R2 window256", result >= 16'd126 && result <= 16'd130, int'(result), 128);
        chk("R9 done seen", nd == 1, nd, 1);
        r0 = int'(result);
        tail(nd);
        chk("R9 single done", nd == 1, nd, 1);
        repeat (20) @(negedge clk);
        chk("R9 result held", int'(result) == r0, int'(result), r0);

        // R2: window 512, osc period 4 -> about 128
        osc_half = 2;
        meas(2'b00, 2'b01, 6'd0, 16'd0, 3000, nd);
        chk("R2 window512", result >= 16'd126 && result <= 16'd130, int'(result), 128);

        // R2: mode 11 alias, tick every 2, osc period 4 -> about 128
        ref_div = 2;
        meas(2'b11, 2'b00, 6'd0, 16'd0, 3000, nd);
        chk("R2 alias mode", result >= 16'd126 && result <= 16'd130, int'(result), 128);

        // R3: tick every 4 -> 1024 cycles, osc period 2 -> 512 edges, wraps
        ref_div = 4; osc_half = 1;
        meas(2'b00, 2'b00, 6'd0, 16'd0, 3000, nd);
        chk("R3 wrap overflow", overflow == 1'b1, int'(overflow), 1);

        // R4: period mode, 5 cycles of period 14, tick every cycle
        ref_div = 1; osc_half = 7;
        meas(2'b01, 2'b00, 6'd5, 16'd0, 3000, nd);
        chk("R4 period count", result >= 16'd57 && result <= 16'd71, int'(result), 70);
        chk("R4 no overflow", overflow == 1'b0, int'(overflow), 0);

        // R5: target 0 means 64 cycles of period 6
        osc_half = 3;
        meas(2'b01, 2'b00, 6'd0, 16'd0, 3000, nd);
        chk("R5 target64", result >= 16'd370 && result <= 16'd390, int'(result), 384);

        // R7: charge mode, tick every 2, comparator rises after 200 cycles
        ref_div = 2; osc_half = 1; cmp_in = 1'b0;
        @(negedge clk);
        mode = 2'b10; timeout = 16'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (199) @(negedge clk);
        cmp_in = 1'b1;
        nd = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (done) begin nd++; break; end
        end
        chk("R7 trip count", result >= 16'd98 && result <= 16'd103, int'(result), 100);
        chk("R7 done", nd == 1, nd, 1);
        cmp_in = 1'b0;
        repeat (4) @(negedge clk);

        // R8: timeout 50, comparator never trips
        ref_div = 1;
        meas(2'b10, 2'b00, 6'd0, 16'd50, 500, nd);
        chk("R8 timeout count", result == 16'd50, int'(result), 50);
        chk("R8 timeout flag", overflow == 1'b1, int'(overflow), 1);

        // R10: start clears overflow; comparator high ends at once, no flag
        cmp_in = 1'b1;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10 overflow cleared", overflow == 1'b0, int'(overflow), 0);
        for (int i = 0; i < 10; i++) begin
            if (done) break;
            @(negedge clk);
        end
        chk("R8 trip beats timeout", overflow == 1'b0, int'(overflow), 0);
        cmp_in = 1'b0;
        repeat (4) @(negedge clk);

        // R10: restart in the middle of a frequency measurement
        osc_half = 1;
        nd = 0;
        @(negedge clk);
        mode = 2'b00; win_sel = 2'b00; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 100; i++) begin @(negedge clk); if (done) nd++; end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 400; i++) begin @(negedge clk); if (done) nd++; end
        chk("R10 restart one done", nd == 1, nd, 1);

        // R6: period target 1 with oscillator stopped; count saturates
        osc_half = 0; osc_manual = 1'b0;
        repeat (4) @(negedge clk);
        @(negedge clk);
        mode = 2'b01; cyc_target = 6'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (66000) @(negedge clk);
        chk("R6 saturated", result == 16'hFFFF, int'(result), 65535);
        chk("R6 overflow", overflow == 1'b1, int'(overflow), 1);
        chk("R6 still running", done == 1'b0, int'(done), 0);

        // R11: one oscillator rise, done after the third edge
        osc_manual = 1'b1;
        @(posedge osc_in);
        @(negedge clk);
        chk("R11 not yet 1", done == 1'b0, int'(done), 0);
        @(negedge clk);
        chk("R11 not yet 2", done == 1'b0, int'(done), 0);
        @(negedge clk);
        chk("R11 done latency", done == 1'b1, int'(done), 1);
        chk("R6 held at max", result == 16'hFFFF, int'(result), 65535);
        repeat (5) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule